// File: doc/BRIEF.md
# Event Trace Recorder with Serial Unload and Preload

This block records selected on-chip events (for example bus transfers) into a small RAM array while the system runs normally. Array storage is not part of the scan chains, so the block has its own way to bring the contents out: after recording stops, a debug request streams every stored entry over a single serial output bit. The same serial port can also fill the array from outside. A debug engineer can load known contents to test a theory about a failure, and then read them back.

Recording is circular. A write pointer walks the array and wraps, and a sticky flag shows that at least one full pass has completed. The pointer and the flag are visible at all times. An external stop input ends recording and freezes the pointer, so the entry count is fixed at that point. Unload and preload are accepted only while the recorder is stopped.

Top module: `trace_buffer`

## Requirements
- R1: After reset the block is not recording, `wr_ptr` is 0, `wrapped`, `busy`, `dbg_valid` and `done` are 0.
- R2: An `arm` pulse (with `stop` low, block not busy) starts recording and clears `wr_ptr` and `wrapped`. While recording, every cycle with `ev_valid` high stores `ev_data` at `wr_ptr` and advances the pointer by one. Cycles with `ev_valid` low store nothing.
- R3: After entry DEPTH-1 is written, the pointer returns to 0 and `wrapped` goes to 1. `wrapped` stays set until the next accepted `arm`.
- R4: `stop` ends recording and has priority over `arm` and over an event in the same cycle. Afterwards `wr_ptr` and `wrapped` do not change when further events arrive.
- R5: An unload sends `wr_ptr` entries, starting at entry 0, when the array has not wrapped. When it has wrapped, it sends DEPTH entries, oldest first, starting at entry `wr_ptr`.
- R6: Unload timing. In the cycle after the request is accepted, bit 0 of the first entry is on `dbg_out` with `dbg_valid` high. One bit follows per cycle, LSB first, with entries back to back and no gaps. `done` is high for one cycle right after the last bit, with `dbg_valid` low. An unload of an empty array gives the `done` pulse alone, in the cycle after the request.
- R7: A preload takes DEPTH×WIDTH bits on `load_bit`, one per cycle from the cycle after the request, LSB first, filling entry 0 upward. The cycle after the last bit, `done` pulses, `wr_ptr` is 0 and `wrapped` is 1, so a following unload returns the loaded contents in order.
- R8: An unload or preload request made while recording is ignored. `dbg_valid`, `done` and `busy` stay low.
- R9: `busy` is high during an unload or preload. An `arm` pulse while busy is ignored, and the block stays not recording.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_data | input | WIDTH | Event word to record |
| ev_valid | input | 1 | Event word is valid this cycle |
| arm | input | 1 | Start recording (pulse) |
| stop | input | 1 | Stop recording |
| dump_req | input | 1 | Request serial unload |
| load_req | input | 1 | Request serial preload |
| load_bit | input | 1 | Serial preload data |
| dbg_out | output | 1 | Serial unload data |
| dbg_valid | output | 1 | `dbg_out` carries a bit this cycle |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | Unload or preload in progress |
| recording | output | 1 | Recorder is armed |
| wr_ptr | output | $clog2(DEPTH) | Current write pointer |
| wrapped | output | 1 | Array has completed a full pass |

## Verification
Control and status outputs change one clock after the input that causes them: `recording`, `wr_ptr` and `wrapped` after `arm`, `stop` or an event. The first unload bit and the start of preload sampling also come one clock after the request. `done` comes one clock after the last bit. The bench drives inputs at the falling edge and reads outputs at the next falling edge, so each output is sampled half a period after the rising edge that should have updated it. During an unload the bench expects a bit on every consecutive falling edge, and it counts any gap before `done` as a failure.

// File: rtl/trace_buffer.sv
module trace_buffer #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         ev_data,
  input  logic                     ev_valid,
  input  logic                     arm,
  input  logic                     stop,
  input  logic                     dump_req,
  input  logic                     load_req,
  input  logic                     load_bit,
  output logic                     dbg_out,
  output logic                     dbg_valid,
  output logic                     done,
  output logic                     busy,
  output logic                     recording,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic                     wrapped
);
  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(WIDTH);
  localparam int CW = AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_DUMP, S_LOAD} st_t;

  st_t              st;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    idx;
  logic [BW-1:0]    bcnt;
  logic [CW-1:0]    left;
  logic [WIDTH-1:0] sh;
  logic             done_q;

  wire idle     = (st == S_IDLE);
  wire go_arm   = arm && !stop && idle;
  wire capture  = recording && ev_valid && !stop && !go_arm;
  wire go_dump  = dump_req && idle && !recording && !go_arm;
  wire go_load  = load_req && idle && !recording && !go_arm && !dump_req;
  wire last_bit = (bcnt == BW'(WIDTH - 1));
  wire [AW-1:0] idx_nx = (idx == AW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  wire [AW-1:0] wp_nx  = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
  wire [CW-1:0] cnt_now = wrapped ? CW'(DEPTH) : {1'b0, wr_ptr};
  wire [WIDTH-1:0] sh_nx = {load_bit, sh[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (capture)
      mem[wr_ptr] <= ev_data;
    else if (st == S_LOAD && last_bit)
      mem[idx] <= sh_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      recording <= 1'b0;
      wr_ptr    <= '0;
      wrapped   <= 1'b0;
      idx       <= '0;
      bcnt      <= '0;
      left      <= '0;
      sh        <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (stop)
        recording <= 1'b0;
      else if (go_arm) begin
        recording <= 1'b1;
        wr_ptr    <= '0;
        wrapped   <= 1'b0;
      end
      if (capture) begin
        wr_ptr <= wp_nx;
        if (wr_ptr == AW'(DEPTH - 1)) wrapped <= 1'b1;
      end
      case (st)
        S_IDLE: begin
          if (go_dump) begin
            if (cnt_now == '0)
              done_q <= 1'b1;
            else begin
              st   <= S_DUMP;
              idx  <= wrapped ? wr_ptr : '0;
              bcnt <= '0;
              left <= cnt_now;
            end
          end else if (go_load) begin
            st   <= S_LOAD;
            idx  <= '0;
            bcnt <= '0;
          end
        end
        S_DUMP: begin
          bcnt <= bcnt + 1'b1;
          if (last_bit) begin
            bcnt <= '0;
            idx  <= idx_nx;
            left <= left - 1'b1;
            if (left == CW'(1)) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        S_LOAD: begin
          sh   <= sh_nx;
          bcnt <= bcnt + 1'b1;
          if (last_bit) begin
            bcnt <= '0;
            idx  <= idx_nx;
            if (idx == AW'(DEPTH - 1)) begin
              st      <= S_IDLE;
              done_q  <= 1'b1;
              wr_ptr  <= '0;
              wrapped <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = !idle;
  assign dbg_valid = (st == S_DUMP);
  assign dbg_out   = dbg_valid ? mem[idx][bcnt] : 1'b0;
  assign done      = done_q;
endmodule

// File: rtl/trace_buffer_chk.sv
module trace_buffer_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ev_valid,
  input logic                     arm,
  input logic                     stop,
  input logic                     dbg_valid,
  input logic                     done,
  input logic                     busy,
  input logic                     recording,
  input logic [$clog2(DEPTH)-1:0] wr_ptr,
  input logic                     wrapped
);
  localparam int AW = $clog2(DEPTH);

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (recording && ev_valid && !stop && !arm) |=>
      (wr_ptr == (($past(wr_ptr) == AW'(DEPTH - 1)) ? '0 : $past(wr_ptr) + 1'b1)));

  p_wrap_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !(arm && !stop && !busy)) |=> wrapped);

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!recording && !(arm && !stop && !busy)) |=> ((wr_ptr == $past(wr_ptr)) || done));

  p_end_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbg_valid) |-> done);

  p_done_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dbg_valid);

  p_quiet_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recording |-> (!dbg_valid && !busy));
endmodule

bind trace_buffer trace_buffer_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .arm(arm), .stop(stop),
  .dbg_valid(dbg_valid), .done(done), .busy(busy), .recording(recording),
  .wr_ptr(wr_ptr), .wrapped(wrapped)
);

// File: tb/trace_buffer_bench.sv
`timescale 1ns/1ps
module trace_buffer_bench;
  localparam int W = 8;
  localparam int D = 16;
  localparam int AW = $clog2(D);
  localparam logic [8:0] VEC [24] = '{
    9'h111, 9'h122, 9'h033, 9'h144, 9'h155, 9'h166, 9'h077, 9'h188,
    9'h199, 9'h1AA, 9'h1BB, 9'h0CC, 9'h1DD, 9'h1EE, 9'h1F0, 9'h101,
    9'h112, 9'h123, 9'h034, 9'h145, 9'h156, 9'h167, 9'h078, 9'h189};

  logic clk = 0, rst_n = 0;
  logic [W-1:0] ev_data = '0;
  logic ev_valid = 0, arm = 0, stop = 0, dump_req = 0, load_req = 0, load_bit = 0;
  logic dbg_out, dbg_valid, done, busy, recording, wrapped;
  logic [AW-1:0] wr_ptr;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [W-1:0] mm [D];
  int mp = 0;
  bit mw = 0;
  logic [W-1:0] got [2*D];
  int gotn;
  bit got_done;

  always #2.5 clk = ~clk;

  trace_buffer #(.WIDTH(W), .DEPTH(D)) u_trace_buffer (
    .clk(clk), .rst_n(rst_n), .ev_data(ev_data), .ev_valid(ev_valid), .arm(arm),
    .stop(stop), .dump_req(dump_req), .load_req(load_req), .load_bit(load_bit),
    .dbg_out(dbg_out), .dbg_valid(dbg_valid), .done(done), .busy(busy),
    .recording(recording), .wr_ptr(wr_ptr), .wrapped(wrapped));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm();
    arm = 1; @(negedge clk); arm = 0;
    mp = 0; mw = 0;
  endtask

  task automatic do_stop();
    stop = 1; @(negedge clk); stop = 0;
  endtask

  task automatic do_dump();
    bit gap = 0;
    gotn = 0; got_done = 0;
    for (int i = 0; i < 2*D; i++) got[i] = '0;
    dump_req = 1; @(negedge clk); dump_req = 0;
    for (int c = 0; c < 2*D*W + 4; c++) begin
      if (dbg_valid) begin
        if (gotn < 2*D*W) got[gotn / W][gotn % W] = dbg_out;
        gotn++;
      end else begin
        if (done) begin got_done = 1; break; end
        gap = 1; break;
      end
      @(negedge clk);
    end
    chk(!gap, "R6 no gap before done", gap, 0);
  endtask

  task automatic do_load(input bit poke_arm);
    load_req = 1; @(negedge clk); load_req = 0;
    for (int e = 0; e < D; e++) begin
      for (int b = 0; b < W; b++) begin
        load_bit = mm[e][b];
        arm = poke_arm && (e == 1) && (b == 3);
        @(negedge clk);
        if (e == 1 && b == 3) chk(busy === 1'b1, "R9 busy during preload", busy, 1);
      end
    end
    arm = 0; load_bit = 0;
  endtask

  task automatic check_dump(input string req, input int nexp, input int start);
    chk(gotn == nexp * W, req, gotn, nexp * W);
    chk(got_done, "R6 done pulse after last bit", got_done, 1);
    for (int i = 0; i < nexp; i++)
      chk(got[i] === mm[(start + i) % D], req, got[i], mm[(start + i) % D]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(recording === 1'b0 && wr_ptr === '0 && wrapped === 1'b0, "R1 reset status",
        {recording, wrapped, wr_ptr}, 0);
    chk(busy === 1'b0 && dbg_valid === 1'b0 && done === 1'b0, "R1 reset outputs",
        {busy, dbg_valid, done}, 0);

    // vector table: recording with wrap
    do_arm();
    chk(recording === 1'b1 && wr_ptr === '0 && wrapped === 1'b0, "R2 arm starts", recording, 1);
    for (int r = 0; r < 24; r++) begin
      ev_valid = VEC[r][8]; ev_data = VEC[r][7:0];
      @(negedge clk);
      if (VEC[r][8]) begin
        mm[mp] = VEC[r][7:0];
        if (mp == D - 1) mw = 1;
        mp = (mp + 1) % D;
      end
      chk(wr_ptr == AW'(mp), "R2 pointer step", wr_ptr, mp);
      chk(wrapped == mw, "R3 wrap flag", wrapped, mw);
    end
    ev_valid = 0;

    // R8 requests while recording ignored
    dump_req = 1; @(negedge clk); dump_req = 0; load_req = 1; @(negedge clk); load_req = 0;
    chk(dbg_valid === 1'b0 && done === 1'b0 && busy === 1'b0, "R8 request ignored while armed",
        {dbg_valid, done, busy}, 0);
    @(negedge clk);
    chk(dbg_valid === 1'b0 && done === 1'b0 && busy === 1'b0, "R8 still idle", {dbg_valid, done, busy}, 0);

    // R4 stop wins over same-cycle event, then freeze
    stop = 1; ev_valid = 1; ev_data = 8'hEE; @(negedge clk); stop = 0;
    chk(recording === 1'b0, "R4 stopped", recording, 0);
    chk(wr_ptr == AW'(mp), "R4 event with stop dropped", wr_ptr, mp);
    repeat (3) @(negedge clk);
    ev_valid = 0;
    chk(wr_ptr == AW'(mp) && wrapped == mw, "R4 frozen after stop", wr_ptr, mp);

    // R5 R6 wrapped unload, oldest first
    do_dump();
    check_dump("R5 wrapped order", D, mp);
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", done, 0);

    // R5 non-wrapped unload from entry 0
    do_arm();
    for (int i = 0; i < 5; i++) begin
      ev_valid = 1; ev_data = W'(8'h30 + i * 7); mm[i] = ev_data;
      @(negedge clk);
    end
    ev_valid = 0; mp = 5;
    // R4 stop has priority over arm
    stop = 1; arm = 1; @(negedge clk); stop = 0; arm = 0;
    chk(recording === 1'b0 && wr_ptr == AW'(5), "R4 stop over arm", wr_ptr, 5);
    do_dump();
    check_dump("R5 unwrapped order", 5, 0);

    // R6 empty unload
    do_arm(); do_stop();
    do_dump();
    chk(gotn == 0 && got_done, "R6 empty unload gives done only", gotn, 0);

    // R7 preload with R9 arm ignored while busy
    for (int i = 0; i < D; i++) mm[i] = W'(i * 37 + 5);
    do_load(1);
    chk(done === 1'b1, "R7 done after preload", done, 1);
    chk(wr_ptr === '0 && wrapped === 1'b1, "R7 status after preload", {wrapped, wr_ptr}, 16);
    chk(recording === 1'b0, "R9 arm during busy ignored", recording, 0);
    @(negedge clk);
    do_dump();
    check_dump("R7 preload readback", D, 0);

    // R3 re-arm clears wrap flag
    do_arm();
    chk(wrapped === 1'b0 && wr_ptr === '0, "R3 arm clears wrap", wrapped, 0);
    do_stop();

    // R1 reset mid-operation
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk(recording === 1'b0 && wr_ptr === '0 && wrapped === 1'b0 && busy === 1'b0,
        "R1 reset again", {recording, wrapped, busy}, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule